// File: doc/BRIEF.md
# Cache Block Maintenance Sequencer

This block carries out one user-level maintenance command on one cache line and decides what that line's coherence state becomes. The commands are touch, touch-for-store, zero, store and flush. The command arrives with the line's current MESI state and the translation and permission attributes of its address. A snoop-response input reports whether another bus participant holds a copy of the line.

From these inputs the block may do up to three things. It may request a bus operation and hold that request until it is granted. It may push modified data into a memory queue and wait for the queue to accept it. It then commits the result in a single cycle. In that cycle the new state, the line-zero strobe, the reference/LRU update pulse and the alignment exception all appear together with done. The cache arrays, the translation unit, bus arbitration and LRU storage live outside the block. Each reaches it through a plain request/acknowledge pair.

Encodings used on the ports:
- Command codes are touch=0, touch-for-store=1, zero=2, store=3 and flush=4. Codes 5 to 7 are unassigned.
- Line states are Invalid=0, Shared=1, Exclusive=2 and Modified=3.
- Bus operations are read=0, kill=1, clean=2 and flush=3.
- A line is exclusively owned when its state is Exclusive or Modified.

Top module: `cbm_ctrl`

## Requirements
- R1: A touch (code 0) whose address misses translation, lacks load permission, falls in a direct-store segment or is non-cacheable completes with done only. It makes no bus request, no push, no state write, no zero strobe and no reference pulse.
- R2: A permitted touch on an Invalid line (0) issues a read bus operation (0). It then writes Exclusive (2) if peer_copy was low at the grant edge, or Shared (1) if it was high. A permitted touch on a valid line leaves the state unwritten. Every permitted touch pulses ref_touch with done.
- R3: Touch-for-store (code 1) behaves exactly like touch in every case.
- R4: A zero (code 2) on a non-cacheable page, a write-through page or a locked/disabled cache asserts excp_align with done. It writes no state, strobes no word and makes no bus request.
- R5: A permitted zero on a line that is not owned (Invalid or Shared) first issues a kill bus operation (1). On an owned line it issues no bus operation. In both cases every bit of zero_we rises in the done cycle.
- R6: A successful zero writes Modified (3).
- R7: A store (code 3) on a Modified line pushes to the memory queue and writes Exclusive (2). On an Exclusive line it does nothing beyond done. On an Invalid or Shared line it issues a clean bus operation (2) and writes no state.
- R8: A flush (code 4) on a Modified line pushes and then writes Invalid. On an Exclusive line it writes Invalid with no bus operation. On a Shared or Invalid line it issues a flush bus operation (3) and writes Invalid.
- R9: Once raised, bus_req stays high with bus_op unchanged until bus_gnt is seen at a clock edge. The request is then dropped.
- R10: Once raised, push_valid stays high until mq_ready is seen. The state commit follows the accepted push.
- R11: cmd_ready is high only while no command is in progress. done is a single-cycle pulse. Opcodes 5 to 7 complete with done alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_op | input | 3 | Command code |
| line_state | input | 2 | Current MESI state of the line |
| xlat_hit | input | 1 | Address hits in translation |
| load_ok | input | 1 | Load access permitted |
| dstore_seg | input | 1 | Address lies in a direct-store segment |
| cacheable | input | 1 | Page is cacheable |
| write_thru | input | 1 | Page is write-through |
| cache_off | input | 1 | Cache locked or disabled |
| peer_copy | input | 1 | Snoop response: another participant holds a copy |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 2 | Bus operation code |
| bus_gnt | input | 1 | Bus operation granted |
| push_valid | output | 1 | Castout push to memory queue |
| mq_ready | input | 1 | Memory queue accepts push |
| zero_we | output | LINE_WORDS | Per-word zero write strobe |
| state_we | output | 1 | Write the new line state |
| state_next | output | 2 | New MESI state |
| ref_touch | output | 1 | Reference bit and LRU update pulse |
| excp_align | output | 1 | Alignment exception |
| done | output | 1 | Command complete, one cycle |

## Verification
The bench builds the block with LINE_WORDS set to 4. This keeps the zero strobe narrow enough to compare as a whole vector, while still showing that every word lane fires together. That small setting lets the bench sweep every command code, every line state, all 64 combinations of the six attribute inputs and both snoop responses. Grant and queue-ready delays rotate between zero and two cycles. This exercises each bus and castout path under both immediate and stalled acknowledgement.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
  typedef enum logic [1:0] {MESI_I = 2'd0, MESI_S = 2'd1, MESI_E = 2'd2, MESI_M = 2'd3} mesi_e;
  typedef enum logic [2:0] {
    OP_TOUCH = 3'd0, OP_TOUCH_ST = 3'd1, OP_ZERO = 3'd2, OP_STORE = 3'd3, OP_FLUSH = 3'd4
  } cmd_e;
  typedef enum logic [1:0] {BOP_READ = 2'd0, BOP_KILL = 2'd1, BOP_CLEAN = 2'd2, BOP_FLUSH = 2'd3} bop_e;

  typedef struct packed {
    logic  need_bus;
    bop_e  bus_op;
    logic  need_push;
    logic  wr_state;
    mesi_e new_state;
    logic  fill;       // final state chosen by snoop response
    logic  zero;
    logic  ref_upd;
    logic  exc;
  } plan_t;
endpackage

// File: rtl/cbm_plan.sv
`timescale 1ns/1ps
module cbm_plan
  import cbm_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] st,
  input  logic       xlat_hit,
  input  logic       load_ok,
  input  logic       dstore_seg,
  input  logic       cacheable,
  input  logic       write_thru,
  input  logic       cache_off,
  output plan_t      plan
);
  mesi_e cur;
  logic  owned;
  logic  touch_ok;
  logic  zero_bad;

  always_comb begin
    cur      = mesi_e'(st);
    owned    = (cur == MESI_E) || (cur == MESI_M);
    touch_ok = xlat_hit && load_ok && !dstore_seg && cacheable;
    zero_bad = !cacheable || write_thru || cache_off;
    plan     = '0;
    case (op)
      OP_TOUCH, OP_TOUCH_ST: begin
        if (touch_ok) begin
          plan.ref_upd = 1'b1;
          if (cur == MESI_I) begin
            plan.need_bus = 1'b1;
            plan.bus_op   = BOP_READ;
            plan.wr_state = 1'b1;
            plan.fill     = 1'b1;
          end
        end
      end
      OP_ZERO: begin
        if (zero_bad) begin
          plan.exc = 1'b1;
        end else begin
          plan.need_bus  = !owned;
          plan.bus_op    = BOP_KILL;
          plan.zero      = 1'b1;
          plan.wr_state  = 1'b1;
          plan.new_state = MESI_M;
        end
      end
      OP_STORE: begin
        if (cur == MESI_M) begin
          plan.need_push = 1'b1;
          plan.wr_state  = 1'b1;
          plan.new_state = MESI_E;
        end else if (!owned) begin
          plan.need_bus = 1'b1;
          plan.bus_op   = BOP_CLEAN;
        end
      end
      OP_FLUSH: begin
        plan.wr_state  = 1'b1;
        plan.new_state = MESI_I;
        plan.need_push = (cur == MESI_M);
        plan.need_bus  = !owned;
        plan.bus_op    = BOP_FLUSH;
      end
      default: plan = '0;
    endcase
  end
endmodule

// File: rtl/cbm_seq.sv
`timescale 1ns/1ps
module cbm_seq
  import cbm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_valid,
  input  plan_t plan_d,
  input  logic  peer_copy,
  input  logic  bus_gnt,
  input  logic  mq_ready,
  output logic  idle,
  output logic  in_bus,
  output logic  in_push,
  output logic  fin,
  output plan_t plan_q,
  output mesi_e fin_state
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_BUS, SQ_PUSH, SQ_FIN} sq_e;
  sq_e  fsm_q, fsm_d;
  logic plan_en, peer_en, peer_q;

  always_comb begin
    fsm_d = fsm_q;
    case (fsm_q)
      SQ_IDLE: if (cmd_valid)
                 fsm_d = plan_d.need_bus ? SQ_BUS : (plan_d.need_push ? SQ_PUSH : SQ_FIN);
      SQ_BUS:  if (bus_gnt) fsm_d = plan_q.need_push ? SQ_PUSH : SQ_FIN;
      SQ_PUSH: if (mq_ready) fsm_d = SQ_FIN;
      default: fsm_d = SQ_IDLE;
    endcase
  end

  assign plan_en = (fsm_q == SQ_IDLE) && cmd_valid;
  assign peer_en = (fsm_q == SQ_BUS) && bus_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= SQ_IDLE;
      plan_q <= '0;
      peer_q <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      if (plan_en) plan_q <= plan_d;
      if (peer_en) peer_q <= peer_copy;
    end
  end

  assign idle      = (fsm_q == SQ_IDLE);
  assign in_bus    = (fsm_q == SQ_BUS);
  assign in_push   = (fsm_q == SQ_PUSH);
  assign fin       = (fsm_q == SQ_FIN);
  assign fin_state = plan_q.fill ? (peer_q ? MESI_S : MESI_E) : plan_q.new_state;
endmodule

// File: rtl/cbm_ctrl.sv
`timescale 1ns/1ps
module cbm_ctrl
  import cbm_pkg::*;
#(
  parameter int LINE_WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [2:0]            cmd_op,
  input  logic [1:0]            line_state,
  input  logic                  xlat_hit,
  input  logic                  load_ok,
  input  logic                  dstore_seg,
  input  logic                  cacheable,
  input  logic                  write_thru,
  input  logic                  cache_off,
  input  logic                  peer_copy,
  output logic                  bus_req,
  output logic [1:0]            bus_op,
  input  logic                  bus_gnt,
  output logic                  push_valid,
  input  logic                  mq_ready,
  output logic [LINE_WORDS-1:0] zero_we,
  output logic                  state_we,
  output logic [1:0]            state_next,
  output logic                  ref_touch,
  output logic                  excp_align,
  output logic                  done
);
  plan_t plan_d, plan_q;
  mesi_e fin_state;
  logic  idle, in_bus, in_push, fin;

  cbm_plan u_plan (
    .op(cmd_op), .st(line_state), .xlat_hit(xlat_hit), .load_ok(load_ok),
    .dstore_seg(dstore_seg), .cacheable(cacheable), .write_thru(write_thru),
    .cache_off(cache_off), .plan(plan_d)
  );

  cbm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .plan_d(plan_d),
    .peer_copy(peer_copy), .bus_gnt(bus_gnt), .mq_ready(mq_ready),
    .idle(idle), .in_bus(in_bus), .in_push(in_push), .fin(fin),
    .plan_q(plan_q), .fin_state(fin_state)
  );

  assign cmd_ready  = idle;
  assign bus_req    = in_bus;
  assign bus_op     = plan_q.bus_op;
  assign push_valid = in_push;
  assign done       = fin;
  assign state_we   = fin && plan_q.wr_state;
  assign state_next = fin_state;
  assign ref_touch  = fin && plan_q.ref_upd;
  assign excp_align = fin && plan_q.exc;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_zero
    assign zero_we[w] = fin && plan_q.zero;
  end
endmodule

// File: rtl/cbm_ctrl_chk.sv
`timescale 1ns/1ps
module cbm_ctrl_chk #(
  parameter int LINE_WORDS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_ready,
  input logic                  bus_req,
  input logic [1:0]            bus_op,
  input logic                  bus_gnt,
  input logic                  push_valid,
  input logic                  mq_ready,
  input logic [LINE_WORDS-1:0] zero_we,
  input logic                  state_we,
  input logic [1:0]            state_next,
  input logic                  excp_align,
  input logic                  done
);
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_op));
  // R9
  bus_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> !bus_req);
  // R10
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !mq_ready |=> push_valid);
  // R10
  push_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && mq_ready |=> done);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_req && !push_valid && !done);
  // R4
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excp_align |-> done && !state_we && (zero_we == '0));
  // R6
  zero_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|zero_we) |-> done && state_we && (state_next == 2'd3) && (&zero_we));
endmodule

bind cbm_ctrl cbm_ctrl_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .bus_req(bus_req),
  .bus_op(bus_op), .bus_gnt(bus_gnt), .push_valid(push_valid), .mq_ready(mq_ready),
  .zero_we(zero_we), .state_we(state_we), .state_next(state_next),
  .excp_align(excp_align), .done(done)
);

// File: tb/test_cbm_ctrl.sv
`timescale 1ns/1ps
module test_cbm_ctrl;
  localparam int LW = 4;
  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [1:0] line_state;
  logic xlat_hit, load_ok, dstore_seg, cacheable, write_thru, cache_off, peer_copy;
  logic bus_req, bus_gnt, push_valid, mq_ready;
  logic [1:0] bus_op;
  logic [LW-1:0] zero_we;
  logic state_we, ref_touch, excp_align, done;
  logic [1:0] state_next;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  cbm_ctrl #(.LINE_WORDS(LW)) i_cbm_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .line_state(line_state), .xlat_hit(xlat_hit), .load_ok(load_ok),
    .dstore_seg(dstore_seg), .cacheable(cacheable), .write_thru(write_thru),
    .cache_off(cache_off), .peer_copy(peer_copy), .bus_req(bus_req), .bus_op(bus_op),
    .bus_gnt(bus_gnt), .push_valid(push_valid), .mq_ready(mq_ready), .zero_we(zero_we),
    .state_we(state_we), .state_next(state_next), .ref_touch(ref_touch),
    .excp_align(excp_align), .done(done)
  );

  task automatic report(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1/R2";
      1: return "R3";
      2: return "R4/R5/R6";
      3: return "R7";
      4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run_one(input int op, input int st, input int attr, input int peer, input int dly);
    int e_bus, e_bop, e_push, e_we, e_ns, e_zero, e_ref, e_exc;
    int n_bus, n_push, a_bop, seen_done;
    bit ok_touch, bad_zero, owned;
    string rq;
    n_bus = 0; n_push = 0; a_bop = 0; seen_done = 0;
    e_bus = 0; e_bop = 0; e_push = 0; e_we = 0; e_ns = 0; e_zero = 0; e_ref = 0; e_exc = 0;
    ok_touch = attr[0] && attr[1] && !attr[2] && attr[3];
    bad_zero = !attr[3] || attr[4] || attr[5];
    owned    = (st >= 2);
    rq = req_of(op);
    // expected outcome from the requirements
    if (op <= 1) begin
      if (ok_touch) begin
        e_ref = 1;
        if (st == 0) begin e_bus = 1; e_bop = 0; e_we = 1; e_ns = peer ? 1 : 2; end
      end
    end else if (op == 2) begin
      if (bad_zero) e_exc = 1;
      else begin e_bus = owned ? 0 : 1; e_bop = 1; e_zero = (1 << LW) - 1; e_we = 1; e_ns = 3; end
    end else if (op == 3) begin
      if (st == 3) begin e_push = 1; e_we = 1; e_ns = 2; end
      else if (!owned) begin e_bus = 1; e_bop = 2; end
    end else if (op == 4) begin
      e_we = 1; e_ns = 0;
      e_push = (st == 3);
      e_bus = owned ? 0 : 1; e_bop = 3;
    end

    @(negedge clk);
    report("R11", "cmd_ready when idle", cmd_ready, 1);
    cmd_op = 3'(op); line_state = 2'(st);
    {cache_off, write_thru, cacheable, dstore_seg, load_ok, xlat_hit} = 6'(attr);
    peer_copy = peer[0];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 3'd7;
    for (int k = 0; k < 20; k++) begin
      if (bus_req) begin
        n_bus++;
        a_bop = bus_op;
        bus_gnt = (n_bus > dly);
      end else bus_gnt = 1'b0;
      if (push_valid) begin
        n_push++;
        mq_ready = (n_push > dly);
      end else mq_ready = 1'b0;
      if (done) begin
        seen_done = 1;
        if (e_we != 0) report(rq, "state_next", state_next, e_ns);
        report(rq, "state_we", state_we, e_we);
        report(rq, "zero_we", zero_we, e_zero);
        report(rq, "ref_touch", ref_touch, e_ref);
        report(rq, "excp_align", excp_align, e_exc);
        report("R11", "cmd_ready during done", cmd_ready, 0);
        break;
      end
      @(negedge clk);
    end
    bus_gnt = 1'b0; mq_ready = 1'b0;
    report(rq, "done seen", seen_done, 1);
    report("R9", "bus_req cycles", n_bus, e_bus ? dly + 1 : 0);
    if (e_bus != 0) report("R9", "bus_op", a_bop, e_bop);
    report("R10", "push cycles", n_push, e_push ? dly + 1 : 0);
    @(negedge clk);
    report("R11", "done single cycle", done, 0);
  endtask

  initial begin
    int idx;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; line_state = '0;
    xlat_hit = 0; load_ok = 0; dstore_seg = 0; cacheable = 0; write_thru = 0;
    cache_off = 0; peer_copy = 0; bus_gnt = 0; mq_ready = 0;
    repeat (3) @(negedge clk);
    report("R11", "reset cmd_ready", cmd_ready, 1);
    report("R11", "reset done", done, 0);
    report("R9", "reset bus_req", bus_req, 0);
    report("R10", "reset push_valid", push_valid, 0);
    rst_n = 1'b1;
    idx = 0;
    for (int op = 0; op < 8; op++)
      for (int st = 0; st < 4; st++)
        for (int attr = 0; attr < 64; attr++)
          for (int peer = 0; peer < 2; peer++) begin
            run_one(op, st, attr, peer, idx % 3);
            idx++;
          end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    wait (cycles >= 190000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule